// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm

This block watches the running minute, hour and weekday of a real-time clock and raises an alarm when they agree with three programmable alarm bytes. Each alarm byte has a mask bit in bit 7. Setting masks from the day upward loosens the match, so the alarm can fire once a week, once a day, once an hour or every minute. The time counters are outside the block. They present their current values together with a one-cycle strobe for the hundredths rollover and a qualifier that marks a rollover that also starts a new minute.

A small byte-wide register port reaches the three alarm bytes and a control byte. The control byte holds a read-only alarm flag, an interrupt mask, a level/pulse select and a source select. The source select hands the shared interrupt output to an external watchdog event instead of the alarm. In level mode the interrupt stays up until software touches an alarm byte. In pulse mode the flag and the interrupt stay high for a fixed number of system-clock cycles. That count is derived from the clock frequency so that the pulse is never shorter than the requested width in milliseconds.

Top module: `tod_alarm`

## Requirements
- R1: After reset the three alarm bytes and the control byte read 0x00, and `irq_o` is low while `wdog_evt_i` is low.
- R2: Address 0 holds the minute alarm, address 1 the hour alarm and address 2 the day alarm. Bit 7 of each byte is its mask bit. Reads return the written value, except that bits 6..3 of the day alarm always read 0.
- R3: At address 3 the control byte uses these bits: bit 0 is the alarm flag (read-only, so writes have no effect on it), bit 2 is the interrupt mask, bit 4 selects pulse mode, and bit 6 selects the watchdog as the interrupt source. Its remaining bits read 0.
- R4: The alarm is evaluated only in a cycle where `tick_i` and `minute_start_i` are both 1. Either strobe on its own never sets the flag.
- R5: With all three mask bits at 0, the flag is set when minute bits 6..0, hour bits 6..0 and day bits 2..0 all equal the alarm bytes.
- R6: With only the day mask set, the flag is set when minute and hour match, whatever the day.
- R7: With the day and hour masks set and the minute mask clear, the flag is set when the minute matches.
- R8: With all three masks set, the flag is set at every evaluation.
- R9: Any read or write of addresses 0 to 2 clears the flag one cycle later. An alarm in the same cycle as such an access wins, and accesses to address 3 do not clear the flag.
- R10: In level mode, with source select 0 and interrupt mask 0, `irq_o` equals the flag and stays high until an access clears it.
- R11: In pulse mode the flag and the interrupt stay high for exactly ceil(CLK_HZ*PULSE_MS/1000) cycles and then drop. A new alarm during the pulse restarts the count.
- R12: With the interrupt mask at 1, `irq_o` stays low for the alarm while the flag is still set and readable.
- R13: With source select 1, `irq_o` follows `wdog_evt_i` in the same cycle, whatever the alarm state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at the hundredths 99 to 00 rollover |
| minute_start_i | input | 1 | Qualifies a tick that also begins a new minute |
| cur_min_i | input | 8 | Current minute, BCD |
| cur_hour_i | input | 8 | Current hour, BCD plus format bits |
| cur_day_i | input | 3 | Current weekday |
| acc_en_i | input | 1 | Register access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 2 | Register index 0..3 |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data of the addressed register (combinational) |
| wdog_evt_i | input | 1 | External watchdog event, level |
| irq_o | output | 1 | Shared interrupt, active high |

## Verification
A wrong match decision, or a mask bit decoded in the wrong place, shows as a flag bit at address 3 and an `irq_o` level that differ from the model in the cycle right after the evaluating tick. A corrupted alarm byte appears on `acc_rdata_o` as soon as the byte is addressed. A pulse counter that is off by one makes the interrupt fall one cycle early or late, so the bench watches every cycle of the pulse. A missed clear leaves the interrupt high in the cycle after the access.

// File: rtl/tod_alarm_pkg.sv
// Shared types and bit positions for the time-of-day alarm.
// Assumes byte-wide registers with the mask bit in the top bit.
package tod_alarm_pkg;
    localparam int REG_W    = 8;
    localparam int MASK_BIT = 7;
    localparam int FIELD_W  = 7;   // compared width of minute and hour
    localparam int DAY_W    = 3;   // compared width of weekday
    localparam int NFIELD   = 3;

    localparam int CTRL_FLAG_BIT  = 0;
    localparam int CTRL_IMASK_BIT = 2;
    localparam int CTRL_PULSE_BIT = 4;
    localparam int CTRL_SEL_BIT   = 6;

    typedef enum logic [1:0] {
        ADDR_MIN  = 2'd0,
        ADDR_HOUR = 2'd1,
        ADDR_DAY  = 2'd2,
        ADDR_CTRL = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [REG_W-1:0] min_alarm;
        logic [REG_W-1:0] hour_alarm;
        logic [REG_W-1:0] day_alarm;
        logic             irq_mask;
        logic             pulse_mode;
        logic             wdog_sel;
    } alarm_cfg_t;
endpackage

// File: rtl/tod_alarm_regs.sv
// Register file of the alarm: three alarm bytes and the control byte.
// Produces the configuration, the read mux and the clear strobe that
// any access to an alarm byte raises. Assumes one access per cycle.
module tod_alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en_i,
    input  logic             acc_we_i,
    input  logic [1:0]       acc_addr_i,
    input  logic [REG_W-1:0] acc_wdata_i,
    input  logic             flag_i,
    output alarm_cfg_t       cfg_o,
    output logic             clr_o,
    output logic [REG_W-1:0] rdata_o
);
    localparam int PAD_W = MASK_BIT - DAY_W;

    alarm_cfg_t cfg_q;
    reg_addr_e  addr;

    assign addr = reg_addr_e'(acc_addr_i);

    // Register writes; the flag bit is not stored here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (acc_en_i && acc_we_i) begin
            case (addr)
                ADDR_MIN:  cfg_q.min_alarm  <= acc_wdata_i;
                ADDR_HOUR: cfg_q.hour_alarm <= acc_wdata_i;
                ADDR_DAY:  cfg_q.day_alarm  <= {acc_wdata_i[MASK_BIT], {PAD_W{1'b0}},
                                                acc_wdata_i[DAY_W-1:0]};
                default: begin
                    cfg_q.irq_mask   <= acc_wdata_i[CTRL_IMASK_BIT];
                    cfg_q.pulse_mode <= acc_wdata_i[CTRL_PULSE_BIT];
                    cfg_q.wdog_sel   <= acc_wdata_i[CTRL_SEL_BIT];
                end
            endcase
        end
    end

    // Read mux of the addressed byte.
    always_comb begin
        rdata_o = '0;
        case (addr)
            ADDR_MIN:  rdata_o = cfg_q.min_alarm;
            ADDR_HOUR: rdata_o = cfg_q.hour_alarm;
            ADDR_DAY:  rdata_o = cfg_q.day_alarm;
            default: begin
                rdata_o[CTRL_FLAG_BIT]  = flag_i;
                rdata_o[CTRL_IMASK_BIT] = cfg_q.irq_mask;
                rdata_o[CTRL_PULSE_BIT] = cfg_q.pulse_mode;
                rdata_o[CTRL_SEL_BIT]   = cfg_q.wdog_sel;
            end
        endcase
    end

    assign cfg_o = cfg_q;
    assign clr_o = acc_en_i && (addr != ADDR_CTRL);
endmodule

// File: rtl/tod_alarm_match.sv
// Compares minute, hour and weekday against the alarm bytes. A field whose
// mask bit is set always counts as matching. Evaluated only on a tick that
// starts a new minute. Mask combinations outside the four legal ones follow
// the same per-field rule; their result is not guaranteed.
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic             tick_i,
    input  logic             minute_start_i,
    input  alarm_cfg_t       cfg_i,
    input  logic [REG_W-1:0] cur_min_i,
    input  logic [REG_W-1:0] cur_hour_i,
    input  logic [DAY_W-1:0] cur_day_i,
    output logic             event_o
);
    localparam int DPAD = FIELD_W - DAY_W;

    logic [FIELD_W-1:0] want [NFIELD];
    logic [FIELD_W-1:0] have [NFIELD];
    logic [NFIELD-1:0]  skip;
    logic [NFIELD-1:0]  field_ok;

    assign want[0] = cfg_i.min_alarm[FIELD_W-1:0];
    assign want[1] = cfg_i.hour_alarm[FIELD_W-1:0];
    assign want[2] = {{DPAD{1'b0}}, cfg_i.day_alarm[DAY_W-1:0]};
    assign have[0] = cur_min_i[FIELD_W-1:0];
    assign have[1] = cur_hour_i[FIELD_W-1:0];
    assign have[2] = {{DPAD{1'b0}}, cur_day_i};
    assign skip    = {cfg_i.day_alarm[MASK_BIT], cfg_i.hour_alarm[MASK_BIT],
                      cfg_i.min_alarm[MASK_BIT]};

    // One comparator per field, bypassed by its mask bit.
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign field_ok[g] = skip[g] | (want[g] == have[g]);
    end

    assign event_o = tick_i & minute_start_i & (&field_ok);
endmodule

// File: rtl/tod_alarm_irq.sv
// Holds the alarm flag and shapes the interrupt. Level mode keeps the flag
// until an access clears it; pulse mode drops it after PULSE_CYCLES cycles.
// The output goes to the watchdog event when the source select is set.
module tod_alarm_irq #(
    parameter int PULSE_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic pulse_mode_i,
    input  logic irq_mask_i,
    input  logic wdog_sel_i,
    input  logic wdog_evt_i,
    output logic flag_o,
    output logic irq_o
);
    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;

    // Flag set, clear and pulse timing; a new alarm takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else if (evt_i) begin
            flag_q <= 1'b1;
            cnt_q  <= '0;
        end else if (clr_i) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else if (flag_q && pulse_mode_i) begin
            if (cnt_q == LAST) begin
                flag_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = wdog_sel_i ? wdog_evt_i : (flag_q & ~irq_mask_i);

    assert_event_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> flag_q);
    assert_access_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !flag_q);
    assert_level_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode_i && flag_q && !clr_i) |=> flag_q);
    assert_pulse_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/tod_alarm.sv
// Top of the maskable time-of-day alarm. Time values and strobes come from
// the calendar counters; the register port is byte wide. The pulse width
// is the requested milliseconds rounded up to whole clock cycles.
module tod_alarm
    import tod_alarm_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int PULSE_MS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             minute_start_i,
    input  logic [7:0]       cur_min_i,
    input  logic [7:0]       cur_hour_i,
    input  logic [2:0]       cur_day_i,
    input  logic             acc_en_i,
    input  logic             acc_we_i,
    input  logic [1:0]       acc_addr_i,
    input  logic [7:0]       acc_wdata_i,
    output logic [7:0]       acc_rdata_o,
    input  logic             wdog_evt_i,
    output logic             irq_o
);
    localparam int PULSE_CYCLES = (CLK_HZ * PULSE_MS + 999) / 1000;

    alarm_cfg_t cfg;
    logic       clr;
    logic       evt;
    logic       flag;

    tod_alarm_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en_i    (acc_en_i),
        .acc_we_i    (acc_we_i),
        .acc_addr_i  (acc_addr_i),
        .acc_wdata_i (acc_wdata_i),
        .flag_i      (flag),
        .cfg_o       (cfg),
        .clr_o       (clr),
        .rdata_o     (acc_rdata_o)
    );

    tod_alarm_match u_match (
        .tick_i         (tick_i),
        .minute_start_i (minute_start_i),
        .cfg_i          (cfg),
        .cur_min_i      (cur_min_i),
        .cur_hour_i     (cur_hour_i),
        .cur_day_i      (cur_day_i),
        .event_o        (evt)
    );

    tod_alarm_irq #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .clr_i        (clr),
        .pulse_mode_i (cfg.pulse_mode),
        .irq_mask_i   (cfg.irq_mask),
        .wdog_sel_i   (cfg.wdog_sel),
        .wdog_evt_i   (wdog_evt_i),
        .flag_o       (flag),
        .irq_o        (irq_o)
    );
endmodule

// File: tb/tod_alarm_tb.sv
module tod_alarm_tb;
    localparam int CLK_HZ    = 10_100;
    localparam int PULSE_MS  = 3;
    localparam int EXP_PULSE = 31;   // 30.3 cycles rounded up

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, tick, mstart, en, we, wdog, irq;
    logic [1:0] addr;
    logic [7:0] wd, rdata, cmin, chr;
    logic [2:0] cday;

    logic [7:0] t_min = 8'h00, t_hr = 8'h00;
    logic [2:0] t_day = 3'd0;
    logic       t_wdog = 1'b0;

    int    vectors = 0;
    int    errs = 0;
    string req = "R1";

    // Behavioural reference state
    logic [7:0] m_min = 0, m_hr = 0, m_day = 0;
    bit m_imask = 0, m_pulse = 0, m_sel = 0, m_flag = 0;
    int m_cnt = 0;

    tod_alarm #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .minute_start_i(mstart),
        .cur_min_i(cmin), .cur_hour_i(chr), .cur_day_i(cday),
        .acc_en_i(en), .acc_we_i(we), .acc_addr_i(addr), .acc_wdata_i(wd),
        .acc_rdata_o(rdata), .wdog_evt_i(wdog), .irq_o(irq)
    );

    function automatic logic [7:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return m_min;
            2'd1: return m_hr;
            2'd2: return m_day;
            default: return {1'b0, m_sel, 1'b0, m_pulse, 1'b0, m_imask, 1'b0, m_flag};
        endcase
    endfunction

    task automatic check();
        logic [7:0] er;
        logic       ei;
        er = exp_rd(addr);
        ei = m_sel ? wdog : (m_flag && !m_imask);
        vectors++;
        if (rdata !== er) begin
            errs++;
            $display("FAIL %s rdata addr %0d: got %h expected %h", req, addr, rdata, er);
        end
        if (irq !== ei) begin
            errs++;
            $display("FAIL %s irq: got %b expected %b", req, irq, ei);
        end
    endtask

    task automatic model_step();
        bit hit, clr;
        hit = tick && mstart
              && (m_min[7] || cmin[6:0] == m_min[6:0])
              && (m_hr[7]  || chr[6:0]  == m_hr[6:0])
              && (m_day[7] || cday      == m_day[2:0]);
        clr = en && (addr != 2'd3);
        if (hit) begin
            m_flag = 1; m_cnt = 0;
        end else if (clr) begin
            m_flag = 0; m_cnt = 0;
        end else if (m_flag && m_pulse) begin
            if (m_cnt == EXP_PULSE - 1) begin m_flag = 0; m_cnt = 0; end
            else m_cnt++;
        end
        if (en && we) begin
            case (addr)
                2'd0: m_min = wd;
                2'd1: m_hr  = wd;
                2'd2: m_day = {wd[7], 4'b0000, wd[2:0]};
                default: begin m_imask = wd[2]; m_pulse = wd[4]; m_sel = wd[6]; end
            endcase
        end
    endtask

    task automatic cyc(input bit t, input bit ms, input bit e, input bit w,
                       input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = t; mstart = ms; en = e; we = w; addr = a; wd = d;
        cmin = t_min; chr = t_hr; cday = t_day; wdog = t_wdog;
        #1;
        check();
        @(posedge clk);
        model_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 2'd3, 8'h00);
    endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d); cyc(0, 0, 1, 1, a, d); endtask
    task automatic rd(input logic [1:0] a); cyc(0, 0, 1, 0, a, 8'h00); endtask
    task automatic atick(); cyc(1, 1, 0, 0, 2'd3, 8'h00); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired in %s", req);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        rst_n = 0; tick = 0; mstart = 0; en = 0; we = 0; addr = 3; wd = 0;
        cmin = 0; chr = 0; cday = 0; wdog = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        req = "R1"; rd(0); rd(1); rd(2); idle(1);
        req = "R2"; wr(0, 8'h45); rd(0); wr(1, 8'h92); rd(1); wr(2, 8'hFF); rd(2);
        req = "R3"; wr(3, 8'hFF); idle(2); wr(3, 8'h00); idle(1);

        wr(0, 8'h30); wr(1, 8'h08); wr(2, 8'h03);
        req = "R5"; t_min = 8'h30; t_hr = 8'h08; t_day = 3'd4; atick(); idle(1);
        req = "R4"; t_day = 3'd3; cyc(1, 0, 0, 0, 2'd3, 0); idle(1); cyc(0, 1, 0, 0, 2'd3, 0); idle(1);
        req = "R5"; atick(); idle(3);
        req = "R10"; idle(8); rd(3); idle(2);
        req = "R9"; rd(2); idle(2);

        req = "R6"; wr(2, 8'h83); t_day = 3'd6; t_hr = 8'h09; atick(); idle(1);
        t_hr = 8'h08; atick(); idle(2); wr(1, 8'h08); idle(2);
        req = "R7"; wr(1, 8'h88); t_hr = 8'h15; t_min = 8'h31; atick(); idle(1);
        t_min = 8'h30; atick(); idle(2); rd(0); idle(1);
        req = "R8"; wr(0, 8'hB0); t_min = 8'h59; atick(); idle(2); rd(1); idle(1);

        req = "R12"; wr(3, 8'h04); atick(); idle(3); rd(0); idle(1);
        req = "R11"; wr(3, 8'h10); atick(); idle(40);
        atick(); idle(10); atick(); idle(40);
        atick(); idle(5); rd(0); idle(3);
        req = "R13"; wr(3, 8'h50); t_wdog = 1; idle(2); t_wdog = 0; idle(2);
        atick(); idle(3); t_wdog = 1; idle(2); t_wdog = 0; idle(32);
        req = "R9"; wr(3, 8'h00); cyc(1, 1, 1, 0, 2'd0, 8'h00); idle(2);
        cyc(0, 0, 1, 0, 2'd3, 8'h00); idle(1); rd(0); idle(2);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule